// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a synchronous model of a parallel NOR flash. Each bus write arrives as a single clocked strobe with its address and data byte already latched. The decoder follows the unlock handshakes that precede every operation. These handshakes form a tree of one-, three-, four- and six-write sequences that share a two-write prefix. When a sequence completes, the decoder emits a one-cycle operation pulse that carries the operation kind and the address and data of the final write. Downstream logic (array, timers, status) acts on that pulse and reports completion back through `op_done`.

The decoder also holds the bus mode (normal read, identification, query) and a sticky single-pulse program mode. In that mode each write is treated directly as a program. It tracks whether an embedded operation is running or suspended, because that decides which writes are decoded at all.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Reset clears the sequence tracker, the mode (read), single-pulse mode, the run state and the pulse outputs in one clock. A sequence that was partly entered before reset has no effect afterwards.
- R2: The writes AA@555h, 55@AAAh, A0@555h arm a program. The next write, at any address, gives a PROG pulse (kind 1) carrying that write's address and data, and `busy` is high from the same edge.
- R3: Only address bits 10:0 are compared against unlock addresses; bit 11 and above are ignored, so 2AAh is accepted where AAAh is expected and 80555h where 555h is expected.
- R4: After AA@555h, 55@AAAh, 80@555h, AA@555h, 55@AAAh, the sixth write selects the operation. 10@555h gives chip erase (kind 2). 30 at any address gives sector erase (kind 3). 60 at any address gives sector lock (kind 4). The two erases set `busy`.
- R5: If the sixth write is A0@555h, the block pulses kind 12 and sets `sp_mode`. From then on, every write made while no operation runs gives a PROG pulse with its own address and data, B0, 30 and F0 included. Only reset clears `sp_mode`.
- R6: B0 at any address while an operation runs gives SUSPEND (kind 5) and sets `suspended`. 30 at any address while suspended gives RESUME (kind 6) and makes the operation run again. Neither byte gives a pulse when nothing is running or suspended.
- R7: While an operation runs, no write except a suspend (and none at all in single-pulse mode) produces a pulse or changes the mode.
- R8: AA@555h, 55@AAAh, 90@555h enters identification (kind 7, `mode`=1). Both F0 at any address and AA@555h, 55@AAAh, F0@555h give kind 8 and return `mode` to 0.
- R9: 98@055h gives kind 9 and sets `mode`=2, from read mode or identification mode.
- R10: A third write of C0@555h makes the next write a protection-register program (kind 11, sets `busy`). A third write of D0@555h makes a next write with data 00 or 01 a configuration write (kind 10). Any other data there gives no pulse.
- R11: A write that does not match the expected next cycle returns the tracker to idle without a pulse, and that same write is decoded again as a first cycle (AA@555h, AA@555h, 55@AAAh, 90@555h still enters identification).
- R12: While suspended, chip and sector erase give no pulse. A program (kinds 1, 11) gives a pulse while an erase is suspended but none while a program is suspended. The run state stays suspended.
- R13: `op_done` ends a running operation at the next edge. A write in the same cycle is decoded as if nothing were running.
- R14: Pulses appear at the clock edge that samples the final write and last exactly one cycle. A cycle without a strobe gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data byte |
| op_done | input | 1 | Running embedded operation has finished |
| op_valid | output | 1 | One-cycle operation pulse |
| op_kind | output | 4 | Operation code (see R2 to R12) |
| op_addr | output | ADDR_W | Address of the write that completed the command |
| op_data | output | 8 | Data of the write that completed the command |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| sp_mode | output | 1 | Single-pulse program mode active |
| busy | output | 1 | Program or erase running |
| suspended | output | 1 | Program or erase suspended |

## Verification
On every cycle, the checker checks the properties that hold on every cycle. A cycle without a strobe never pulses. Single-pulse mode never drops and turns each idle-state write into a program of that write. A running operation lets nothing but a suspend through. A suspend pulse always coincides with the suspended state, and erases never start while suspended. The bench scenarios are the only way to show that the full unlock tree resolves each branch correctly. They also cover the re-decoding of mismatched writes, the mode transitions between read, identification and query, the same-cycle interplay of `op_done` with a write, and the loss of a half-entered sequence across reset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int DATA_W = 8;
    localparam int CMP_W  = 11;

    localparam logic [CMP_W-1:0] ADR_UNLK_A = 11'h555;
    localparam logic [CMP_W-1:0] ADR_UNLK_B = 11'h2AA;
    localparam logic [CMP_W-1:0] ADR_QUERY  = 11'h055;

    localparam logic [DATA_W-1:0] D_KEY1  = 8'hAA;
    localparam logic [DATA_W-1:0] D_KEY2  = 8'h55;
    localparam logic [DATA_W-1:0] D_PROG  = 8'hA0;
    localparam logic [DATA_W-1:0] D_EXT   = 8'h80;
    localparam logic [DATA_W-1:0] D_IDENT = 8'h90;
    localparam logic [DATA_W-1:0] D_PROT  = 8'hC0;
    localparam logic [DATA_W-1:0] D_CFG   = 8'hD0;
    localparam logic [DATA_W-1:0] D_EXIT  = 8'hF0;
    localparam logic [DATA_W-1:0] D_QUERY = 8'h98;
    localparam logic [DATA_W-1:0] D_SUSP  = 8'hB0;
    localparam logic [DATA_W-1:0] D_RES   = 8'h30;
    localparam logic [DATA_W-1:0] D_CHIP  = 8'h10;
    localparam logic [DATA_W-1:0] D_SECT  = 8'h30;
    localparam logic [DATA_W-1:0] D_LOCK  = 8'h60;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROG       = 4'd1,
        OP_CHIP_ERASE = 4'd2,
        OP_SECT_ERASE = 4'd3,
        OP_SECT_LOCK  = 4'd4,
        OP_SUSPEND    = 4'd5,
        OP_RESUME     = 4'd6,
        OP_ID_ENTER   = 4'd7,
        OP_ID_EXIT    = 4'd8,
        OP_QUERY      = 4'd9,
        OP_CFG_WRITE  = 4'd10,
        OP_PROT_PROG  = 4'd11,
        OP_SP_ENTER   = 4'd12
    } op_kind_e;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_QUERY = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        RUN_IDLE   = 3'd0,
        RUN_PROG   = 3'd1,
        RUN_ERASE  = 3'd2,
        SUSP_PROG  = 3'd3,
        SUSP_ERASE = 3'd4
    } run_e;

    typedef enum logic [3:0] {
        SQ_IDLE  = 4'd0,
        SQ_UNLK1 = 4'd1,
        SQ_UNLK2 = 4'd2,
        SQ_PROG  = 4'd3,
        SQ_PROT  = 4'd4,
        SQ_CFG   = 4'd5,
        SQ_EXT1  = 4'd6,
        SQ_EXT2  = 4'd7,
        SQ_EXT3  = 4'd8
    } seq_e;

    typedef struct packed {
        op_kind_e kind;
        seq_e     next;
    } dec_t;

    function automatic logic is_running(run_e r);
        return (r == RUN_PROG) || (r == RUN_ERASE);
    endfunction

    function automatic logic is_suspended(run_e r);
        return (r == SUSP_PROG) || (r == SUSP_ERASE);
    endfunction

    // Decode of a write seen with no sequence in progress.
    function automatic dec_t first_cycle(logic [CMP_W-1:0] a,
                                         logic [DATA_W-1:0] d,
                                         mode_e m, run_e r);
        dec_t res;
        res.kind = OP_NONE;
        res.next = SQ_IDLE;
        if (d == D_SUSP && is_running(r))
            res.kind = OP_SUSPEND;
        else if (d == D_RES && is_suspended(r))
            res.kind = OP_RESUME;
        else if (d == D_EXIT)
            res.kind = OP_ID_EXIT;
        else if (d == D_QUERY && a == ADR_QUERY && m != MODE_QUERY)
            res.kind = OP_QUERY;
        else if (d == D_KEY1 && a == ADR_UNLK_A)
            res.next = SQ_UNLK1;
        return res;
    endfunction

endpackage

// File: rtl/fcd_seq_tracker.sv
module fcd_seq_tracker
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_strobe,
    input  logic [CMP_W-1:0]  wr_low,
    input  logic [DATA_W-1:0] wr_data,
    input  mode_e             mode,
    input  run_e              run_eff,
    input  logic              sp_mode,
    output op_kind_e          cmd_kind
);

    seq_e seq_q;
    dec_t fc;
    dec_t dec;

    always_comb begin
        fc  = first_cycle(wr_low, wr_data, mode, run_eff);
        dec = '{kind: OP_NONE, next: seq_q};
        if (wr_strobe) begin
            if (sp_mode) begin
                dec.next = SQ_IDLE;
                if (run_eff == RUN_IDLE)
                    dec.kind = OP_PROG;
            end else if (is_running(run_eff)) begin
                if (fc.kind == OP_SUSPEND)
                    dec = '{kind: OP_SUSPEND, next: SQ_IDLE};
            end else begin
                unique case (seq_q)
                    SQ_UNLK1: begin
                        if (wr_low == ADR_UNLK_B && wr_data == D_KEY2)
                            dec.next = SQ_UNLK2;
                        else
                            dec = fc;
                    end
                    SQ_UNLK2: begin
                        dec = fc;
                        if (wr_low == ADR_UNLK_A) begin
                            case (wr_data)
                                D_PROG:  dec = '{kind: OP_NONE,     next: SQ_PROG};
                                D_EXT:   dec = '{kind: OP_NONE,     next: SQ_EXT1};
                                D_PROT:  dec = '{kind: OP_NONE,     next: SQ_PROT};
                                D_CFG:   dec = '{kind: OP_NONE,     next: SQ_CFG};
                                D_IDENT: dec = '{kind: OP_ID_ENTER, next: SQ_IDLE};
                                D_EXIT:  dec = '{kind: OP_ID_EXIT,  next: SQ_IDLE};
                                default: dec = fc;
                            endcase
                        end
                    end
                    SQ_PROG: dec = '{kind: OP_PROG,      next: SQ_IDLE};
                    SQ_PROT: dec = '{kind: OP_PROT_PROG, next: SQ_IDLE};
                    SQ_CFG: begin
                        if (wr_data == 8'h00 || wr_data == 8'h01)
                            dec = '{kind: OP_CFG_WRITE, next: SQ_IDLE};
                        else
                            dec = fc;
                    end
                    SQ_EXT1: begin
                        if (wr_low == ADR_UNLK_A && wr_data == D_KEY1)
                            dec.next = SQ_EXT2;
                        else
                            dec = fc;
                    end
                    SQ_EXT2: begin
                        if (wr_low == ADR_UNLK_B && wr_data == D_KEY2)
                            dec.next = SQ_EXT3;
                        else
                            dec = fc;
                    end
                    SQ_EXT3: begin
                        if (wr_data == D_SECT)
                            dec = '{kind: OP_SECT_ERASE, next: SQ_IDLE};
                        else if (wr_data == D_LOCK)
                            dec = '{kind: OP_SECT_LOCK, next: SQ_IDLE};
                        else if (wr_data == D_CHIP && wr_low == ADR_UNLK_A)
                            dec = '{kind: OP_CHIP_ERASE, next: SQ_IDLE};
                        else if (wr_data == D_PROG && wr_low == ADR_UNLK_A)
                            dec = '{kind: OP_SP_ENTER, next: SQ_IDLE};
                        else
                            dec = fc;
                    end
                    default: dec = fc;
                endcase
                // Operations forbidden while something is suspended.
                if (run_eff == SUSP_ERASE &&
                    (dec.kind == OP_CHIP_ERASE || dec.kind == OP_SECT_ERASE))
                    dec.kind = OP_NONE;
                if (run_eff == SUSP_PROG &&
                    (dec.kind == OP_CHIP_ERASE || dec.kind == OP_SECT_ERASE ||
                     dec.kind == OP_PROG || dec.kind == OP_PROT_PROG))
                    dec.kind = OP_NONE;
            end
        end
    end

    assign cmd_kind = dec.kind;

    always_ff @(posedge clk) begin
        if (rst)
            seq_q <= SQ_IDLE;
        else if (wr_strobe)
            seq_q <= dec.next;
    end

endmodule

// File: rtl/fcd_mode_ctrl.sv
module fcd_mode_ctrl
    import fcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_kind_e cmd_kind,
    output mode_e    mode,
    output logic     sp_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_READ;
            sp_mode <= 1'b0;
        end else begin
            case (cmd_kind)
                OP_ID_ENTER: mode <= MODE_IDENT;
                OP_QUERY:    mode <= MODE_QUERY;
                OP_ID_EXIT:  mode <= MODE_READ;
                OP_SP_ENTER: begin
                    mode    <= MODE_READ;
                    sp_mode <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fcd_run_ctrl.sv
module fcd_run_ctrl
    import fcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_kind_e cmd_kind,
    input  logic     op_done,
    output run_e     run_q,
    output run_e     run_eff
);

    run_e run_d;

    // A completion reported this cycle makes the write of this cycle see idle.
    assign run_eff = (is_running(run_q) && op_done) ? RUN_IDLE : run_q;

    always_comb begin
        run_d = run_eff;
        case (cmd_kind)
            OP_PROG, OP_PROT_PROG: if (run_eff == RUN_IDLE) run_d = RUN_PROG;
            OP_CHIP_ERASE, OP_SECT_ERASE: if (run_eff == RUN_IDLE) run_d = RUN_ERASE;
            OP_SUSPEND: begin
                if (run_eff == RUN_PROG)       run_d = SUSP_PROG;
                else if (run_eff == RUN_ERASE) run_d = SUSP_ERASE;
            end
            OP_RESUME: begin
                if (run_eff == SUSP_PROG)       run_d = RUN_PROG;
                else if (run_eff == SUSP_ERASE) run_d = RUN_ERASE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= RUN_IDLE;
        else
            run_q <= run_d;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        mode,
    output logic              sp_mode,
    output logic              busy,
    output logic              suspended
);

    localparam int LOW_W = (ADDR_W < CMP_W) ? ADDR_W : CMP_W;

    logic [CMP_W-1:0] wr_low;
    op_kind_e         cmd_kind;
    mode_e            mode_q;
    run_e             run_q;
    run_e             run_eff;

    generate
        if (ADDR_W >= CMP_W) begin : g_low_full
            assign wr_low = wr_addr[LOW_W-1:0];
        end else begin : g_low_pad
            assign wr_low = {{(CMP_W-LOW_W){1'b0}}, wr_addr};
        end
    endgenerate

    fcd_seq_tracker u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_strobe(wr_strobe),
        .wr_low   (wr_low),
        .wr_data  (wr_data),
        .mode     (mode_q),
        .run_eff  (run_eff),
        .sp_mode  (sp_mode),
        .cmd_kind (cmd_kind)
    );

    fcd_mode_ctrl u_mode (
        .clk     (clk),
        .rst     (rst),
        .cmd_kind(cmd_kind),
        .mode    (mode_q),
        .sp_mode (sp_mode)
    );

    fcd_run_ctrl u_run (
        .clk     (clk),
        .rst     (rst),
        .cmd_kind(cmd_kind),
        .op_done (op_done),
        .run_q   (run_q),
        .run_eff (run_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= (cmd_kind != OP_NONE);
            op_kind  <= cmd_kind;
            if (cmd_kind != OP_NONE) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign mode      = mode_q;
    assign busy      = is_running(run_q);
    assign suspended = is_suspended(run_q);

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_strobe,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic              op_valid,
    input logic [3:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] op_data,
    input logic [1:0]        mode,
    input logic              sp_mode,
    input logic              busy,
    input logic              suspended
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!op_valid && mode == MODE_READ && !sp_mode && !busy && !suspended));

    // R14
    no_strobe_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> !op_valid);

    // R14
    pulse_has_kind_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_kind != OP_NONE));

    // R5
    sp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sp_mode |=> sp_mode);

    // R5
    sp_write_programs_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_mode && !busy && !suspended && wr_strobe) |=>
            (op_valid && op_kind == OP_PROG &&
             op_addr == $past(wr_addr) && op_data == $past(wr_data)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_done && wr_strobe) |=> (!op_valid || op_kind == OP_SUSPEND));

    // R6
    suspend_state_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_SUSPEND) |-> suspended);

    // R12
    no_erase_in_suspend_chk: assert property (@(posedge clk) disable iff (rst)
        (suspended && wr_strobe) |=>
            !(op_valid && (op_kind == OP_CHIP_ERASE || op_kind == OP_SECT_ERASE)));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_strobe(wr_strobe),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .op_done  (op_done),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .mode     (mode),
    .sp_mode  (sp_mode),
    .busy     (busy),
    .suspended(suspended)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int AW = 20;
    localparam int NV = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_strobe = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          op_done = 1'b0;
    logic          op_valid;
    logic [3:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic [1:0]    mode;
    logic          sp_mode;
    logic          busy;
    logic          suspended;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .op_done(op_done), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .mode(mode), .sp_mode(sp_mode), .busy(busy), .suspended(suspended)
    );

    // s: strobe, dn: op_done, a/d: write, k: expected kind (0 = no pulse),
    // m: expected mode, b: expected busy
    typedef struct packed {
        logic          s;
        logic          dn;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [3:0]    k;
        logic [1:0]    m;
        logic          b;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R2
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hA0, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h01234, 8'h5A, 4'd1,  2'd0, 1'b1},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b1}, // R7
        '{1'b0, 1'b1, 20'h00000, 8'h00, 4'd0,  2'd0, 1'b0}, // R13
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R4
        '{1'b1, 1'b0, 20'h002AA, 8'h55, 4'd0,  2'd0, 1'b0}, // R3
        '{1'b1, 1'b0, 20'h00555, 8'h80, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h48000, 8'h30, 4'd3,  2'd0, 1'b1},
        '{1'b1, 1'b0, 20'h00000, 8'hB0, 4'd5,  2'd0, 1'b0}, // R6
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R12
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hA0, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00100, 8'h11, 4'd1,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R12
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h80, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h10, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00000, 8'h30, 4'd6,  2'd0, 1'b1}, // R6
        '{1'b0, 1'b1, 20'h00000, 8'h00, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00000, 8'hB0, 4'd0,  2'd0, 1'b0}, // R6
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R8
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h90, 4'd7,  2'd1, 1'b0},
        '{1'b1, 1'b0, 20'h00055, 8'h98, 4'd9,  2'd2, 1'b0}, // R9
        '{1'b1, 1'b0, 20'h00777, 8'hF0, 4'd8,  2'd0, 1'b0}, // R8
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R11
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h90, 4'd7,  2'd1, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd1, 1'b0}, // R8
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd1, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hF0, 4'd8,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h80555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R3
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hD0, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00000, 8'h07, 4'd0,  2'd0, 1'b0}, // R10
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hD0, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00000, 8'h01, 4'd10, 2'd0, 1'b0}, // R10
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hC0, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00081, 8'h3C, 4'd11, 2'd0, 1'b1}, // R10
        '{1'b0, 1'b1, 20'h00000, 8'h00, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R4
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h80, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h10000, 8'h60, 4'd4,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0}, // R4
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h80, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'hAA, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00AAA, 8'h55, 4'd0,  2'd0, 1'b0},
        '{1'b1, 1'b0, 20'h00555, 8'h10, 4'd2,  2'd0, 1'b1},
        '{1'b0, 1'b1, 20'h00000, 8'h00, 4'd0,  2'd0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One cycle of stimulus, sampled just after the edge that takes it.
    task automatic step(input logic s, input logic dn,
                        input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_strobe = s;
        op_done   = dn;
        wr_addr   = a;
        wr_data   = d;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        step(1'b1, 1'b0, a, d);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_strobe = 1'b0;
        op_done = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "op_valid", op_valid, 0);
        chk("R1", "mode", mode, 0);
        chk("R1", "sp_mode", sp_mode, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "suspended", suspended, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].s, VEC[i].dn, VEC[i].a, VEC[i].d);
            chk($sformatf("table %0d", i), "op_valid", op_valid, (VEC[i].k != 0));
            if (VEC[i].k != 0)
                chk($sformatf("table %0d", i), "op_kind", op_kind, VEC[i].k);
            chk($sformatf("table %0d", i), "mode", mode, VEC[i].m);
            chk($sformatf("table %0d", i), "busy", busy, VEC[i].b);
        end

        // R2 program carries address and data
        wr(20'h00555, 8'hAA); wr(20'h00AAA, 8'h55); wr(20'h00555, 8'hA0);
        wr(20'h03000, 8'h77);
        chk("R2", "op_kind", op_kind, 1);
        chk("R2", "op_addr", op_addr, 20'h03000);
        chk("R2", "op_data", op_data, 8'h77);
        chk("R2", "busy", busy, 1);
        // R6 suspend of a program
        wr(20'h00000, 8'hB0);
        chk("R6", "op_kind", op_kind, 5);
        chk("R6", "suspended", suspended, 1);
        // R12 program refused while a program is suspended
        wr(20'h00555, 8'hAA); wr(20'h00AAA, 8'h55); wr(20'h00555, 8'hA0);
        wr(20'h04000, 8'h12);
        chk("R12", "op_valid", op_valid, 0);
        chk("R12", "suspended", suspended, 1);
        wr(20'h00000, 8'h30);
        chk("R6", "op_kind", op_kind, 6);
        chk("R6", "busy", busy, 1);
        // R13 write in the completion cycle is seen as idle: B0 not a suspend
        step(1'b1, 1'b1, 20'h00000, 8'hB0);
        chk("R13", "op_valid", op_valid, 0);
        chk("R13", "busy", busy, 0);
        chk("R13", "suspended", suspended, 0);
        // R14 no strobe, no pulse
        step(1'b0, 1'b0, 20'h00000, 8'h00);
        chk("R14", "op_valid", op_valid, 0);
        // R6 resume byte with nothing suspended
        wr(20'h00000, 8'h30);
        chk("R6", "op_valid", op_valid, 0);
        chk("R6", "busy", busy, 0);

        // R5 single-pulse program mode
        wr(20'h00555, 8'hAA); wr(20'h00AAA, 8'h55); wr(20'h00555, 8'h80);
        wr(20'h00555, 8'hAA); wr(20'h00AAA, 8'h55); wr(20'h00555, 8'hA0);
        chk("R5", "op_kind", op_kind, 12);
        chk("R5", "sp_mode", sp_mode, 1);
        wr(20'h00022, 8'hB0);
        chk("R5", "op_kind", op_kind, 1);
        chk("R5", "op_addr", op_addr, 20'h00022);
        chk("R5", "op_data", op_data, 8'hB0);
        chk("R5", "busy", busy, 1);
        // R7 in single-pulse mode even B0 is ignored while busy
        wr(20'h00555, 8'hB0);
        chk("R7", "op_valid", op_valid, 0);
        chk("R7", "suspended", suspended, 0);
        step(1'b0, 1'b1, 20'h00000, 8'h00);
        wr(20'h00033, 8'h30);
        chk("R5", "op_kind", op_kind, 1);
        chk("R5", "op_data", op_data, 8'h30);
        step(1'b0, 1'b1, 20'h00000, 8'h00);
        wr(20'h00777, 8'hF0);
        chk("R5", "op_kind", op_kind, 1);
        chk("R5", "sp_mode", sp_mode, 1);
        step(1'b0, 1'b1, 20'h00000, 8'h00);

        // R1 reset leaves single-pulse mode
        pulse_reset();
        #1;
        chk("R1", "sp_mode", sp_mode, 0);
        chk("R1", "mode", mode, 0);
        chk("R1", "busy", busy, 0);
        // R1 half-entered sequence lost across reset
        wr(20'h00555, 8'hAA); wr(20'h00AAA, 8'h55);
        pulse_reset();
        wr(20'h00555, 8'hA0);
        wr(20'h01234, 8'h5A);
        chk("R1", "op_valid", op_valid, 0);
        chk("R1", "busy", busy, 0);

        step(1'b0, 1'b0, 20'h00000, 8'h00);
        finish_run();
    end

endmodule